// File: doc/BRIEF.md
# Taken-Branch Flush Controller

This block carries out the assume-not-taken policy for control hazards in a five-stage in-order pipeline. Fetch keeps moving down the sequential path. Only a taken branch costs anything. The branch outcome and its target address become known when the branch reaches the memory stage. At that point three younger instructions are already in flight on the wrong path, and each of them has to be removed.

Each of the three wrong-path slots is removed in its own way. The decode-side pipeline register is loaded with an all-zero instruction word. The instruction in decode is turned into a no-op by the same control-zeroing bubble that a load-use stall uses. The instruction in execute keeps its result, but its destination register number is forced to 0, so the write goes nowhere. In the same cycle the block owns the fetch PC and loads the branch target into it.

The block also receives the load-use stall request from the hazard detector. When both arrive together, the flush takes priority. The flush lasts one cycle. The instruction fetched from the target on the next cycle moves on normally.

Top module: `flush_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc_o` is loaded with the parameter `RESET_PC`.
- R2: With `mem_taken_i` low and `load_stall_i` low, the outputs are: `pc_sel_o` = 0 (sequential), `pc_load_o` = 1, `ifid_load_o` = 1, `ifid_clear_o` = 0 and `idex_bubble_o` = 0. After the next edge, `fetch_pc_o` equals the `seq_pc_i` value from the previous cycle.
- R3: With `mem_taken_i` high, `pc_sel_o` = 2 (target) and `pc_load_o` = 1. After the next edge, `fetch_pc_o` equals the `mem_target_i` value from the previous cycle.
- R4: With `mem_taken_i` high, `ifid_clear_o` = 1 and `ifid_load_o` = 1, so an all-zero instruction word is written into the decode register.
- R5: With `mem_taken_i` high, `idex_bubble_o` = 1.
- R6: With `mem_taken_i` high, `exmem_rd_o` = 0. Otherwise `exmem_rd_o` equals `ex_rd_i`.
- R7: With `load_stall_i` high and `mem_taken_i` low, the outputs are: `pc_sel_o` = 1 (hold), `pc_load_o` = 0, `ifid_load_o` = 0, `ifid_clear_o` = 0 and `idex_bubble_o` = 1. `fetch_pc_o` keeps its value across the edge.
- R8: With both `mem_taken_i` and `load_stall_i` high, the flush wins. Outputs and PC behave exactly as R3 to R6 state, and the stall has no effect.
- R9: A flush affects only the cycle in which `mem_taken_i` is high. In the next cycle, with `mem_taken_i` low, the outputs follow R2 or R7 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_taken_i | input | 1 | Branch in the memory stage resolved taken |
| mem_target_i | input | ADDR_W | Target address of the resolved branch |
| seq_pc_i | input | ADDR_W | Sequential next fetch address |
| load_stall_i | input | 1 | Load-use stall request from the hazard detector |
| ex_rd_i | input | REG_W | Destination register of the instruction in execute |
| pc_sel_o | output | 2 | Next-PC source: 0 sequential, 1 hold, 2 target |
| pc_load_o | output | 1 | Fetch PC write enable |
| fetch_pc_o | output | ADDR_W | Current fetch address |
| ifid_load_o | output | 1 | Decode pipeline register write enable |
| ifid_clear_o | output | 1 | Write zero into the decode instruction field |
| idex_bubble_o | output | 1 | Zero all control fields entering execute |
| exmem_rd_o | output | REG_W | Destination register passed to the memory stage |

## Verification
The bench sweeps every combination of taken and stall. Each combination is applied under several target, sequential and register patterns, including register 0 and the highest register number. Three faults get particular attention:
- A design that ranks the stall above the flush would hold the PC and leave a wrong-path instruction alive in decode when both requests arrive together.
- A design that leaves the flush active for more than one cycle would squash the first correct instruction from the target.
- A design that passes the execute destination through during a flush would let a wrong-path result reach the register file.

The PC checks are made one edge later. They catch a target or sequential address that was captured a cycle late or early.

// File: rtl/flush_pkg.sv
package flush_pkg;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'd0,
        PC_HOLD   = 2'd1,
        PC_TARGET = 2'd2
    } pc_sel_e;

    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,
        ACT_STALL = 2'd1,
        ACT_FLUSH = 2'd2
    } pipe_act_e;

    typedef struct packed {
        logic ifid_load;
        logic ifid_clear;
        logic idex_bubble;
        logic kill_ex_rd;
    } squash_t;

    function automatic pipe_act_e pick_action(input logic taken, input logic stall);
        if (taken)      return ACT_FLUSH;
        else if (stall) return ACT_STALL;
        else            return ACT_RUN;
    endfunction

    function automatic pc_sel_e pc_source(input pipe_act_e act);
        case (act)
            ACT_FLUSH: return PC_TARGET;
            ACT_STALL: return PC_HOLD;
            default:   return PC_SEQ;
        endcase
    endfunction

endpackage

// File: rtl/flush_arbiter.sv
module flush_arbiter
    import flush_pkg::*;
(
    input  logic      taken_i,
    input  logic      stall_i,
    output pipe_act_e act_o
);
    always_comb begin
        act_o = pick_action(taken_i, stall_i);
    end
endmodule

// File: rtl/pc_steer.sv
module pc_steer
    import flush_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]   RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  pipe_act_e         act_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] seq_i,
    output pc_sel_e           sel_o,
    output logic              load_o,
    output logic [ADDR_W-1:0] pc_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        sel_o  = pc_source(act_i);
        load_o = (sel_o != PC_HOLD);
        case (sel_o)
            PC_TARGET: pc_d = target_i;
            PC_SEQ:    pc_d = seq_i;
            default:   pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         pc_q <= RESET_PC;
        else if (load_o) pc_q <= pc_d;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/stage_squash.sv
module stage_squash
    import flush_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  pipe_act_e        act_i,
    input  logic [REG_W-1:0] ex_rd_i,
    output squash_t          sq_o,
    output logic [REG_W-1:0] rd_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        sq_o = '0;
        case (act_i)
            ACT_FLUSH: begin
                sq_o.ifid_load   = 1'b1;
                sq_o.ifid_clear  = 1'b1;
                sq_o.idex_bubble = 1'b1;
                sq_o.kill_ex_rd  = 1'b1;
            end
            ACT_STALL: begin
                sq_o.ifid_load   = 1'b0;
                sq_o.idex_bubble = 1'b1;
            end
            default: begin
                sq_o.ifid_load   = 1'b1;
            end
        endcase
        rd_o = sq_o.kill_ex_rd ? ZERO_REG : ex_rd_i;
    end
endmodule

// File: rtl/flush_ctrl.sv
module flush_ctrl
    import flush_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter int unsigned       REG_W    = 5,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_taken_i,
    input  logic [ADDR_W-1:0] mem_target_i,
    input  logic [ADDR_W-1:0] seq_pc_i,
    input  logic              load_stall_i,
    input  logic [REG_W-1:0]  ex_rd_i,
    output logic [1:0]        pc_sel_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] fetch_pc_o,
    output logic              ifid_load_o,
    output logic              ifid_clear_o,
    output logic              idex_bubble_o,
    output logic [REG_W-1:0]  exmem_rd_o
);
    pipe_act_e act;
    pc_sel_e   sel;
    squash_t   sq;

    flush_arbiter u_arb (
        .taken_i (mem_taken_i),
        .stall_i (load_stall_i),
        .act_o   (act)
    );

    pc_steer #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .act_i    (act),
        .target_i (mem_target_i),
        .seq_i    (seq_pc_i),
        .sel_o    (sel),
        .load_o   (pc_load_o),
        .pc_o     (fetch_pc_o)
    );

    stage_squash #(.REG_W(REG_W)) u_sq (
        .act_i   (act),
        .ex_rd_i (ex_rd_i),
        .sq_o    (sq),
        .rd_o    (exmem_rd_o)
    );

    assign pc_sel_o      = sel;
    assign ifid_load_o   = sq.ifid_load;
    assign ifid_clear_o  = sq.ifid_clear;
    assign idex_bubble_o = sq.idex_bubble;
endmodule

// File: rtl/flush_ctrl_chk.sv
module flush_ctrl_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned REG_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_taken_i,
    input logic [ADDR_W-1:0] mem_target_i,
    input logic [ADDR_W-1:0] seq_pc_i,
    input logic              load_stall_i,
    input logic [REG_W-1:0]  ex_rd_i,
    input logic [1:0]        pc_sel_o,
    input logic              pc_load_o,
    input logic [ADDR_W-1:0] fetch_pc_o,
    input logic              ifid_load_o,
    input logic              ifid_clear_o,
    input logic              idex_bubble_o,
    input logic [REG_W-1:0]  exmem_rd_o
);
    assert_run_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_taken_i && !load_stall_i) |=> fetch_pc_o == $past(seq_pc_i));

    assert_target_pc_R3: assert property (@(posedge clk) disable iff (rst)
        mem_taken_i |=> fetch_pc_o == $past(mem_target_i));

    assert_ifid_zero_R4: assert property (@(posedge clk) disable iff (rst)
        mem_taken_i |-> (ifid_clear_o && ifid_load_o));

    assert_clear_needs_load_R4: assert property (@(posedge clk) disable iff (rst)
        ifid_clear_o |-> ifid_load_o);

    assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        mem_taken_i |-> idex_bubble_o);

    assert_rd_kill_R6: assert property (@(posedge clk) disable iff (rst)
        mem_taken_i |-> exmem_rd_o == '0);

    assert_rd_pass_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_taken_i |-> exmem_rd_o == ex_rd_i);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (load_stall_i && !mem_taken_i) |=> $stable(fetch_pc_o));

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_taken_i && load_stall_i) |-> (pc_load_o && pc_sel_o == 2'd2));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_taken_i |-> !ifid_clear_o);
endmodule

bind flush_ctrl flush_ctrl_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_taken_i   (mem_taken_i),
    .mem_target_i  (mem_target_i),
    .seq_pc_i      (seq_pc_i),
    .load_stall_i  (load_stall_i),
    .ex_rd_i       (ex_rd_i),
    .pc_sel_o      (pc_sel_o),
    .pc_load_o     (pc_load_o),
    .fetch_pc_o    (fetch_pc_o),
    .ifid_load_o   (ifid_load_o),
    .ifid_clear_o  (ifid_clear_o),
    .idex_bubble_o (idex_bubble_o),
    .exmem_rd_o    (exmem_rd_o)
);

// File: tb/flush_ctrl_test.sv
`timescale 1ns/1ps
module flush_ctrl_test;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned REG_W  = 5;
    localparam logic [ADDR_W-1:0] RST_PC = 32'h0000_1000;

    logic              clk = 1'b0;
    logic              rst;
    logic              taken, stall;
    logic [ADDR_W-1:0] target, seq;
    logic [REG_W-1:0]  ex_rd;
    logic [1:0]        pc_sel;
    logic              pc_load, ifid_load, ifid_clear, idex_bubble;
    logic [ADDR_W-1:0] fetch_pc;
    logic [REG_W-1:0]  rd_out;

    int checks = 0;
    int errors = 0;
    logic [ADDR_W-1:0] exp_pc;
    bit done = 0;

    always #5 clk = ~clk;

    flush_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W), .RESET_PC(RST_PC)) uut (
        .clk           (clk),
        .rst           (rst),
        .mem_taken_i   (taken),
        .mem_target_i  (target),
        .seq_pc_i      (seq),
        .load_stall_i  (stall),
        .ex_rd_i       (ex_rd),
        .pc_sel_o      (pc_sel),
        .pc_load_o     (pc_load),
        .fetch_pc_o    (fetch_pc),
        .ifid_load_o   (ifid_load),
        .ifid_clear_o  (ifid_clear),
        .idex_bubble_o (idex_bubble),
        .exmem_rd_o    (rd_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One pipeline cycle: drive at negedge, check combinational outputs,
    // then check the fetch PC after the rising edge.
    task automatic step(input logic t, input logic s, input logic [ADDR_W-1:0] tg,
                        input logic [ADDR_W-1:0] sq, input logic [REG_W-1:0] rd,
                        input string tag);
        logic [1:0] e_sel;
        @(negedge clk);
        taken = t; stall = s; target = tg; seq = sq; ex_rd = rd;
        #1;
        if (t) begin
            e_sel = 2'd2;
            chk({tag, " R3 sel"}, 64'(pc_sel), 64'(e_sel));
            chk({tag, " R3 load"}, 64'(pc_load), 64'd1);
            chk({tag, " R4 ifid"}, 64'({ifid_load, ifid_clear}), 64'd3);
            chk({tag, " R5 bubble"}, 64'(idex_bubble), 64'd1);
            chk({tag, " R6 rd"}, 64'(rd_out), 64'd0);
            if (s) chk({tag, " R8 flush wins"}, 64'({pc_load, pc_sel}), 64'h6);
            exp_pc = tg;
        end else if (s) begin
            chk({tag, " R7 sel"}, 64'(pc_sel), 64'd1);
            chk({tag, " R7 ctl"}, 64'({pc_load, ifid_load, ifid_clear, idex_bubble}), 64'h1);
            chk({tag, " R6 pass"}, 64'(rd_out), 64'(rd));
        end else begin
            chk({tag, " R2 sel"}, 64'(pc_sel), 64'd0);
            chk({tag, " R2 ctl"}, 64'({pc_load, ifid_load, ifid_clear, idex_bubble}), 64'hC);
            chk({tag, " R6 pass"}, 64'(rd_out), 64'(rd));
            exp_pc = sq;
        end
        @(posedge clk);
        #1;
        chk({tag, t ? " R3 pc" : (s ? " R7 pc" : " R2 pc")}, 64'(fetch_pc), 64'(exp_pc));
    endtask

    initial begin
        rst = 1'b1; taken = 0; stall = 0; target = '0; seq = '0; ex_rd = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pc", 64'(fetch_pc), 64'(RST_PC));
        exp_pc = RST_PC;
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 4; c++) begin
                logic [ADDR_W-1:0] base;
                logic [REG_W-1:0]  rd;
                base = 32'h0000_2000 + 32'(k) * 32'h104 + 32'(c) * 32'h10;
                rd   = (k == 0) ? 5'd0 : ((k == 7) ? 5'd31 : 5'((k * 7 + c * 3) % 32));
                step(c[1], c[0], (base ^ 32'hA5A0_0000) + 32'(k * 16), base + 4, rd, "sweep");
                // R9: cycle after any flush returns to normal flow
                if (c[1]) step(1'b0, 1'b0, 32'hDEAD_0000, base + 32'h40, rd ^ 5'h15, "R9 after flush");
            end
        end
        // back-to-back flushes and stall following flush
        step(1, 0, 32'h0000_8000, 32'h0000_0100, 5'd9, "flush1");
        step(1, 1, 32'h0000_9000, 32'h0000_0200, 5'd10, "flush2");
        step(0, 1, 32'h0000_A000, 32'h0000_0300, 5'd11, "R9 stall after flush");
        step(0, 0, 32'h0000_B000, 32'h0000_0400, 5'd12, "R9 run");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule